// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block takes over once a program, sector-erase or chip-erase command has already been sent to a parallel flash device. The flash device runs the operation on its own internal timer. The poller keeps reading a status byte from the device through a simple request/acknowledge read port until the byte shows that the operation has finished. It then takes one more read to confirm the final contents. It ends by raising exactly one of three one-cycle outcome pulses: finished, timed out, or failed confirmation.

Two detection methods are available. In the first, the poller compares the top data bit with the value the finished operation must leave there. In the second, it watches the next bit down and treats the operation as finished when that bit reads the same in two reads in a row; the bit alternates on every read while the device is busy.

A prescaled tick clocks a timeout counter. Each operation kind has its own limit. All limits and the tick period are parameters, so a simulation can use short windows. The device has 512 sectors of 1 KB, and the upper nine address bits select the sector.

Top module: `flash_done_poller`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is sampled low, busy, rd_req, op_done, op_timeout and op_error are all 0. A reset in the middle of an operation abandons that operation.
- R2: A start pulse seen while idle latches op_kind, method, target_addr and wdata, and busy is 1 on the next cycle. A start pulse seen while busy has no effect on the running operation, its read address or its outcome.
- R3: op_kind 2'b00 is a byte program, 2'b01 a sector erase and 2'b10 a chip erase. Every read of an operation uses one fixed address: target_addr for a program, the sector base {target_addr[18:10], 10'b0} for a sector erase, and 0 for a chip erase.
- R4: rd_req stays high with rd_addr unchanged until a cycle with rd_ack high. A read completes in each cycle where rd_req and rd_ack are both high, and rd_data is taken in that cycle.
- R5: With method 0, a read completes the polling phase when rd_data[7] equals the expected bit. The expected bit is wdata[7] for a program and 1 for either erase. Bit 6 is ignored in this method.
- R6: With method 1, the first read of an operation only serves as a reference. A later read completes the polling phase when its rd_data[6] equals rd_data[6] of the read before it. Bit 7 is ignored in this method.
- R7: After the polling phase completes, exactly one confirming read is made. If that byte equals the expected final byte (wdata for a program, 8'hFF for an erase), op_done pulses. Otherwise op_error pulses.
- R8: A timer counts ticks of TICK_DIV cycles from the start pulse. It expires after PROG_TICKS, SECT_TICKS or CHIP_TICKS ticks, according to the operation kind. When a polling read that does not show completion returns after expiry, op_timeout pulses and no further read is made.
- R9: Each operation ends with exactly one of op_done, op_timeout or op_error high for one cycle. busy is 0 in that cycle, and the pulse follows the cycle of the last completed read.
- R10: op_kind 2'b11 behaves exactly as a chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| op_kind | input | 2 | Operation kind (program, sector erase, chip erase) |
| method | input | 1 | 0: top-bit compare, 1: toggle-bit watch |
| target_addr | input | 19 | Byte address the command targeted |
| wdata | input | 8 | Byte that was programmed |
| rd_req | output | 1 | Read request to the bus interface |
| rd_addr | output | 19 | Read address |
| rd_ack | input | 1 | Read completed, rd_data valid |
| rd_data | input | 8 | Byte returned by the read |
| busy | output | 1 | Operation being polled |
| op_done | output | 1 | Pulse: finished and confirmed |
| op_timeout | output | 1 | Pulse: limit exceeded |
| op_error | output | 1 | Pulse: confirming read mismatched |

## Verification
The assertions assume that rd_ack is high only while rd_req is high, that rd_data is meaningful only in the acknowledge cycle, and that start lasts one cycle. The bench's read responder meets these assumptions: it answers only a pending request, after a fixed latency, and drops the acknowledge one cycle later. It returns a byte pattern computed from a per-test busy count. Busy bytes carry the inverted expected top bit and an alternating bit 6. Bytes after the busy phase return the chosen final byte, so each detection method and each outcome can be steered. Start pulses come from one task that holds start for a single cycle, including the pulse injected during a running operation.

// File: rtl/flash_poll_pkg.sv
// Shared encodings for the flash completion poller.
package flash_poll_pkg;

    // Operation kind as presented on op_kind; 2'b11 is treated as chip erase.
    typedef enum logic [1:0] {
        OP_PROG     = 2'b00,
        OP_SECT     = 2'b01,
        OP_CHIP     = 2'b10,
        OP_CHIP_ALT = 2'b11
    } op_kind_e;

    // Detection method as presented on method.
    typedef enum logic {
        DET_TOPBIT = 1'b0,
        DET_TOGGLE = 1'b1
    } det_method_e;

    // Controller states.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_POLL    = 2'b01,
        ST_CONFIRM = 2'b10
    } poll_state_e;

endpackage

// File: rtl/poll_tick_gen.sv
// Prescaler producing a one-cycle tick every TICK_DIV cycles while run is high.
// Assumes: clear restarts the phase so the first tick is TICK_DIV cycles after it.
module poll_tick_gen #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);

    generate
        if (TICK_DIV <= 1) begin : g_passthru
            // Every running cycle is a tick.
            assign tick = run;
        end else begin : g_div
            localparam int PW = $clog2(TICK_DIV);
            localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] phase_q;

            // Phase counter, wraps at TICK_DIV-1.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    phase_q <= '0;
                end else if (run) begin
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
                end
            end

            assign tick = run && (phase_q == LAST);

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);  // R8
        end
    endgenerate

endmodule

// File: rtl/poll_timer.sv
// Per-operation timeout: counts prescaled ticks since clear, saturating,
// and flags expiry when the count reaches the limit for op_kind.
// Assumes: op_kind is stable while run is high.
module poll_timer
    import flash_poll_pkg::*;
#(
    parameter int TICK_DIV   = 50,
    parameter int PROG_TICKS = 20,
    parameter int SECT_TICKS = 10000,
    parameter int CHIP_TICKS = 2000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       run,
    input  logic [1:0] op_kind,
    output logic       expired
);

    localparam int MAX_A = (PROG_TICKS > SECT_TICKS) ? PROG_TICKS : SECT_TICKS;
    localparam int MAXL  = (MAX_A > CHIP_TICKS) ? MAX_A : CHIP_TICKS;
    localparam int CW    = $clog2(MAXL + 1);

    logic          tick;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    poll_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .run   (run),
        .tick  (tick)
    );

    // Select the window belonging to the operation kind.
    always_comb begin
        case (op_kind_e'(op_kind))
            OP_PROG: limit = CW'(PROG_TICKS);
            OP_SECT: limit = CW'(SECT_TICKS);
            default: limit = CW'(CHIP_TICKS);
        endcase
    end

    // Saturating tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != {CW{1'b1}})) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= limit);

    AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear) |=> (cnt_q >= $past(cnt_q)));  // R8
    AST_CLEAR_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));  // R8

endmodule

// File: rtl/poll_judge.sv
// Combinational evaluation of one returned status byte: whether it ends
// the polling phase, and whether it equals the expected final byte.
// Assumes: have_prev is 0 for the first read of an operation.
module poll_judge
    import flash_poll_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic              method,
    input  logic              exp_hi,
    input  logic              have_prev,
    input  logic              prev_tog,
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] final_exp,
    output logic              complete,
    output logic              final_ok
);

    // Completion test depends on the chosen method.
    always_comb begin
        if (det_method_e'(method) == DET_TOGGLE) begin
            complete = have_prev && (sample[TOG_BIT] == prev_tog);
        end else begin
            complete = (sample[POLL_BIT] == exp_hi);
        end
    end

    assign final_ok = (sample == final_exp);

endmodule

// File: rtl/flash_done_poller.sv
// Flash completion poller top: latches an operation on start, issues status
// reads to a fixed address, decides completion by top-bit compare or toggle
// watch, takes one confirming read and reports done, timeout or error.
// Assumes: rd_ack only while rd_req is high; start is a one-cycle pulse.
module flash_done_poller
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int SECT_W     = 9,
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = 7,
    parameter int TOG_BIT    = 6,
    parameter int TICK_DIV   = 50,
    parameter int PROG_TICKS = 20,
    parameter int SECT_TICKS = 10000,
    parameter int CHIP_TICKS = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic              method,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              op_done,
    output logic              op_timeout,
    output logic              op_error
);

    localparam int OFS_W = ADDR_W - SECT_W;

    poll_state_e       state_q;
    logic [1:0]        op_q;
    logic              meth_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] final_q;
    logic              prev_tog_q;
    logic              have_prev_q;
    logic              done_q, tmo_q, err_q;

    logic [ADDR_W-1:0] start_addr;
    logic [DATA_W-1:0] start_final;
    logic              accept;
    logic              xfer;
    logic              complete, final_ok;
    logic              tmr_expired;

    assign accept = (state_q == ST_IDLE) && start;
    assign xfer   = rd_req && rd_ack;

    // Poll address and expected final byte for the incoming operation.
    always_comb begin
        case (op_kind_e'(op_kind))
            OP_PROG: begin
                start_addr  = target_addr;
                start_final = wdata;
            end
            OP_SECT: begin
                start_addr  = {target_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
                start_final = {DATA_W{1'b1}};
            end
            default: begin
                start_addr  = '0;
                start_final = {DATA_W{1'b1}};
            end
        endcase
    end

    poll_timer #(
        .TICK_DIV   (TICK_DIV),
        .PROG_TICKS (PROG_TICKS),
        .SECT_TICKS (SECT_TICKS),
        .CHIP_TICKS (CHIP_TICKS)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (busy),
        .op_kind (op_q),
        .expired (tmr_expired)
    );

    poll_judge #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) judge_i (
        .method    (meth_q),
        .exp_hi    (final_q[POLL_BIT]),
        .have_prev (have_prev_q),
        .prev_tog  (prev_tog_q),
        .sample    (rd_data),
        .final_exp (final_q),
        .complete  (complete),
        .final_ok  (final_ok)
    );

    // Operation context, latched only when accepted from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            meth_q  <= 1'b0;
            addr_q  <= '0;
            final_q <= '0;
        end else if (accept) begin
            op_q    <= op_kind;
            meth_q  <= method;
            addr_q  <= start_addr;
            final_q <= start_final;
        end
    end

    // Toggle reference: bit sampled by the previous completed read.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            prev_tog_q  <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (xfer && state_q == ST_POLL) begin
            prev_tog_q  <= rd_data[TOG_BIT];
            have_prev_q <= 1'b1;
        end
    end

    // Control sequence and one-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) state_q <= ST_POLL;
                end
                ST_POLL: begin
                    if (xfer) begin
                        if (complete) begin
                            state_q <= ST_CONFIRM;
                        end else if (tmr_expired) begin
                            state_q <= ST_IDLE;
                            tmo_q   <= 1'b1;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (xfer) begin
                        state_q <= ST_IDLE;
                        done_q  <= final_ok;
                        err_q   <= !final_ok;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign rd_req     = busy;
    assign rd_addr    = addr_q;
    assign op_done    = done_q;
    assign op_timeout = tmo_q;
    assign op_error   = err_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);  // R4
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> $stable(rd_addr));  // R4
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);  // R2
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({op_done, op_timeout, op_error}) <= 1);  // R9
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done || op_timeout || op_error) |=> !(op_done || op_timeout || op_error));  // R9
    AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done || op_timeout || op_error) |-> !busy);  // R9
    AST_RESULT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done || op_timeout || op_error) |-> $past(rd_req && rd_ack));  // R7
    AST_TIMEOUT_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        op_timeout |-> $past(tmr_expired));  // R8

endmodule

// File: tb/flash_done_poller_tb_top.sv
module flash_done_poller_tb_top;

    localparam int DIV = 4, LP = 6, LS = 15, LC = 25, LAT = 2;

    typedef struct packed {
        logic [1:0]  op;
        logic        meth;
        logic [18:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  busy;
        logic [7:0]  fin;
        logic [1:0]  res;   // 0 done, 1 timeout, 2 error
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 19'h12345, 8'hA5, 8'd3,   8'hA5, 2'd0},  // R5 program
        '{2'd0, 1'b0, 19'h00010, 8'h3C, 8'd0,   8'h3C, 2'd0},  // R5 bit7 low
        '{2'd0, 1'b1, 19'h7FFFF, 8'h5A, 8'd4,   8'h5A, 2'd0},  // R6 program
        '{2'd1, 1'b0, 19'h2A7FF, 8'h00, 8'd6,   8'hFF, 2'd0},  // R3 sector
        '{2'd1, 1'b1, 19'h40400, 8'h00, 8'd2,   8'hFF, 2'd0},  // R6 sector
        '{2'd2, 1'b0, 19'h00001, 8'h00, 8'd10,  8'hFF, 2'd0},  // R3 chip
        '{2'd0, 1'b0, 19'h00100, 8'h81, 8'd2,   8'h80, 2'd2},  // R7 error
        '{2'd1, 1'b1, 19'h00003, 8'h00, 8'd3,   8'hEF, 2'd2},  // R7 error
        '{2'd0, 1'b0, 19'h01234, 8'h11, 8'd200, 8'h11, 2'd1},  // R8 program
        '{2'd1, 1'b1, 19'h05555, 8'h00, 8'd200, 8'hFF, 2'd1},  // R8 sector
        '{2'd2, 1'b0, 19'h00777, 8'h00, 8'd200, 8'hFF, 2'd1},  // R8 chip
        '{2'd3, 1'b0, 19'h55555, 8'h00, 8'd1,   8'hFF, 2'd0}   // R10
    };

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, method = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [18:0] target_addr = '0, rd_addr;
    logic [7:0]  wdata = '0, rd_data;
    logic        rd_req, rd_ack, busy, op_done, op_timeout, op_error;

    int n_chk = 0, n_bad = 0;
    int busy_n = 0, rd_cnt = 0, addr_bad = 0;
    logic [7:0]  fin_m = '0;
    logic        exp7_m = 1'b1;
    logic [18:0] exp_addr_m = '0;

    always #10 clk = ~clk;

    flash_done_poller #(.TICK_DIV(DIV), .PROG_TICKS(LP), .SECT_TICKS(LS), .CHIP_TICKS(LC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind), .method(method),
        .target_addr(target_addr), .wdata(wdata), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .op_done(op_done),
        .op_timeout(op_timeout), .op_error(op_error));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Device model: busy bytes carry inverted top bit and alternating bit 6.
    function automatic logic [7:0] model_byte(input int idx);
        logic b6;
        b6 = idx[0];
        if (idx < busy_n) return {~exp7_m, b6, 6'h15};
        return fin_m;
    endfunction

    function automatic int exp_reads(input logic meth);
        logic [7:0] a, b;
        if (!meth) return busy_n + 2;
        for (int i = 1; i < busy_n + 3; i++) begin
            a = model_byte(i);
            b = model_byte(i - 1);
            if (a[6] == b[6]) return i + 2;
        end
        return -1;
    endfunction

    function automatic logic [18:0] map_addr(input logic [1:0] op, input logic [18:0] a);
        if (op == 2'd0) return a;
        if (op == 2'd1) return {a[18:10], 10'b0};
        return '0;
    endfunction

    // Read responder.
    initial begin
        rd_ack = 1'b0;
        rd_data = '0;
        forever begin
            @(negedge clk);
            rd_ack = 1'b0;
            if (rst_n && rd_req) begin
                if (rd_addr !== exp_addr_m) addr_bad++;
                repeat (LAT) @(negedge clk);
                if (rst_n && rd_req) begin
                    rd_data = model_byte(rd_cnt);
                    rd_ack = 1'b1;
                    rd_cnt++;
                end
            end
        end
    end

    task automatic run_op(input vec_t v, input int k, input int poke);
        int el, code, lim;
        exp7_m = (v.op == 2'd0) ? v.wdata[7] : 1'b1;
        busy_n = v.busy;
        fin_m = v.fin;
        exp_addr_m = map_addr(v.op, v.addr);
        rd_cnt = 0;
        addr_bad = 0;
        @(negedge clk);
        op_kind = v.op; method = v.meth; target_addr = v.addr; wdata = v.wdata; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        el = 1;
        chk(busy == 1'b1, $sformatf("R2 busy after start v%0d", k), busy, 1);
        while (!(op_done || op_timeout || op_error) && el < 3000) begin
            @(negedge clk);
            el++;
            if (el == poke) begin
                op_kind = 2'd2; target_addr = 19'h70000; wdata = 8'h00; method = ~v.meth; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        code = op_done ? 0 : op_timeout ? 1 : op_error ? 2 : 3;
        chk(code == v.res, $sformatf("R5 R6 R7 R8 outcome v%0d", k), code, v.res);
        chk(addr_bad == 0, $sformatf("R3 read address v%0d", k), addr_bad, 0);
        chk(busy == 1'b0, $sformatf("R9 busy low at outcome v%0d", k), busy, 0);
        if (v.res != 2'd1) begin
            chk(rd_cnt == exp_reads(v.meth), $sformatf("R4 R6 R7 read count v%0d", k), rd_cnt, exp_reads(v.meth));
        end else begin
            lim = (v.op == 2'd0) ? LP * DIV : (v.op == 2'd1) ? LS * DIV : LC * DIV;
            chk(el >= lim - 1 && el <= lim + 8, $sformatf("R8 timeout window v%0d", k), el, lim);
        end
        @(negedge clk);
        chk(!(op_done || op_timeout || op_error), $sformatf("R9 single pulse v%0d", k),
            int'({op_done, op_timeout, op_error}), 0);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        vec_t v;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!busy && !rd_req && !op_done && !op_timeout && !op_error, "R1 reset outputs",
            int'({busy, rd_req, op_done, op_timeout, op_error}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) run_op(VECS[k], k, 0);

        // R2: start while busy is ignored
        v = '{2'd0, 1'b0, 19'h0ABCD, 8'h77, 8'd5, 8'h77, 2'd0};
        run_op(v, 100, 4);

        // R1: reset mid-operation abandons it
        busy_n = 200; exp7_m = 1'b1; fin_m = 8'hFF; exp_addr_m = '0; rd_cnt = 0;
        @(negedge clk);
        op_kind = 2'd2; method = 1'b0; target_addr = 19'h1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !rd_req, "R1 mid-op reset", int'({busy, rd_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !op_done && !op_timeout && !op_error, "R1 idle after reset",
            int'({busy, op_done, op_timeout, op_error}), 0);
        run_op(VECS[0], 200, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule